// File: doc/BRIEF.md
# Dual-Mode Digital Waveform Synthesizer

This block feeds an external D/A converter with one signed amplitude sample per clock. In tone mode it is a tunable synthesizer. A phase register of `PHASE_W` bits grows by a step word on each enabled clock. A phase shift is added to the result, and only the top `ADDR_W` bits of the sum select an entry of a sine table built at elaboration. The output frequency is therefore `step * fclk / 2^PHASE_W`.

In replay mode the same output path reads a second table, a fixed stored waveform. It reads one entry per enabled clock, in order, and starts again from index zero after a programmable count of entries. The step word has no effect in this mode.

The step word, the phase shift and the replay length are held in registers at the boundary, so a change takes effect one clock later. The sample and its valid flag come out two clocks after the phase or index that produced them.

Top module: `dds_dual_synth`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the phase, the replay index and both pipeline stages. After that edge, `sample` is 0 and `sample_valid` is 0.
- R2: In tone mode (`mode`=0), each enabled clock adds the registered step word to the phase modulo 2^PHASE_W. On overflow the remainder is kept, not cleared.
- R3: In tone mode the table index is the top ADDR_W bits of (phase + registered shift) mod 2^PHASE_W. The sample equals round((2^(SAMPLE_W-1)-1)·sin(2π·index/2^ADDR_W)), with an error of at most one LSB.
- R4: A phase shift of zero gives the plain accumulator phase. A nonzero shift moves the table index by the top bits of the shifted sum.
- R5: `step`, `phase_shift` and `replay_len` are captured at a clock edge. The phase update and the table lookup use the captured values from the next edge onward.
- R6: In replay mode (`mode`=1), each enabled clock advances the replay index by exactly one, whatever the step word is. Entry i of the stored waveform is (i − 2^(PLAY_AW−1))·2^(SAMPLE_W−PLAY_AW).
- R7: The replay index returns to 0 on the step after it reaches `replay_len`−1. With a length of 0 or 1 it stays at 0. If the length is lowered below the current index, the index returns to 0 on the next step.
- R8: A clock edge at which `mode` differs from the registered mode resets both the phase and the replay index to 0 and adopts the new mode. No step is taken at that edge.
- R9: When `en` is low, the phase and the replay index hold. `sample_valid` equals `en` from two edges earlier, and `sample` is the table value for the phase or index held two edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; also the source of the valid flag |
| mode | input | 1 | 0 = tone synthesis, 1 = stored-waveform replay |
| step | input | PHASE_W | Frequency step word added to the phase each enabled clock |
| phase_shift | input | PHASE_W | Phase shift added before the table lookup |
| replay_len | input | PLAY_AW+1 | Number of stored entries played before restarting |
| sample | output | SAMPLE_W | Signed two's-complement amplitude |
| sample_valid | output | 1 | Sample corresponds to an enabled clock |

## Verification
The bench uses step words that overflow the phase on almost every clock. A design that cleared the phase on overflow, or kept the wrong bits when truncating, would then pick the wrong sine entries at once. It changes the step and the shift on every clock, which catches a design that uses a word one cycle early or one cycle late.

In replay mode it programs lengths of 0, 1 and short odd values, and lowers the length while the index is already past it. An off-by-one wrap shows up as one entry too many or too few. It also switches modes in the middle of a run and toggles the enable. A design that did not restart from zero on a mode change, or that kept stepping while disabled, would return a sample from the wrong position.

// File: rtl/dds_pkg.sv
package dds_pkg;

  typedef enum logic {
    MODE_TONE   = 1'b0,
    MODE_REPLAY = 1'b1
  } wave_mode_e;

  // Rounded sine amplitude for table index idx out of 2^addr_w entries.
  function automatic int sine_code(int idx, int addr_w, int samp_w);
    real amp;
    real ang;
    real r;
    amp = real'((1 << (samp_w - 1)) - 1);
    ang = 2.0 * 3.14159265358979 * real'(idx) / real'(1 << addr_w);
    r   = amp * $sin(ang);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(0.5 - r);
  endfunction

  // Stored replay waveform: a full-scale rising ramp centred on zero.
  function automatic int ramp_code(int idx, int play_aw, int samp_w);
    return (idx - (1 << (play_aw - 1))) * (1 << (samp_w - play_aw));
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               adv,
  input  logic [PHASE_W-1:0] inc,
  output logic [PHASE_W-1:0] phase
);

  always_ff @(posedge clk) begin
    if (rst || clear) phase <= '0;
    else if (adv)     phase <= phase + inc;
  end

endmodule

// File: rtl/dds_play_ctr.sv
module dds_play_ctr #(
  parameter int PLAY_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               adv,
  input  logic [PLAY_AW:0]   len,
  output logic [PLAY_AW-1:0] idx
);

  logic [PLAY_AW:0] nxt;
  assign nxt = {1'b0, idx} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clear)  idx <= '0;
    else if (adv) begin
      if (nxt >= len)  idx <= '0;
      else             idx <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/dds_wave_rom.sv
module dds_wave_rom #(
  parameter int ADDR_W   = 8,
  parameter int PLAY_AW  = 6,
  parameter int SAMPLE_W = 12
) (
  input  logic                       sel_replay,
  input  logic [ADDR_W-1:0]          sin_addr,
  input  logic [PLAY_AW-1:0]         play_addr,
  output logic signed [SAMPLE_W-1:0] value
);

  localparam int SIN_DEPTH  = 1 << ADDR_W;
  localparam int PLAY_DEPTH = 1 << PLAY_AW;

  logic signed [SAMPLE_W-1:0] sin_tab  [SIN_DEPTH];
  logic signed [SAMPLE_W-1:0] play_tab [PLAY_DEPTH];

  for (genvar i = 0; i < SIN_DEPTH; i++) begin : g_sin
    assign sin_tab[i] = SAMPLE_W'(dds_pkg::sine_code(i, ADDR_W, SAMPLE_W));
  end

  for (genvar j = 0; j < PLAY_DEPTH; j++) begin : g_play
    assign play_tab[j] = SAMPLE_W'(dds_pkg::ramp_code(j, PLAY_AW, SAMPLE_W));
  end

  assign value = sel_replay ? play_tab[play_addr] : sin_tab[sin_addr];

endmodule

// File: rtl/dds_dual_synth.sv
module dds_dual_synth #(
  parameter int PHASE_W  = 24,
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 12,
  parameter int PLAY_AW  = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       mode,
  input  logic [PHASE_W-1:0]         step,
  input  logic [PHASE_W-1:0]         phase_shift,
  input  logic [PLAY_AW:0]           replay_len,
  output logic signed [SAMPLE_W-1:0] sample,
  output logic                       sample_valid
);
  import dds_pkg::*;

  localparam int DROP_W = PHASE_W - ADDR_W;

  // Captured control words
  logic [PHASE_W-1:0] fcw_q;
  logic [PHASE_W-1:0] shift_q;
  logic [PLAY_AW:0]   len_q;
  wave_mode_e         mode_q;

  // Named events for the checker
  logic mode_chg;
  logic acc_step;
  logic play_step;

  logic [PHASE_W-1:0] phase;
  logic [PLAY_AW-1:0] play_idx;
  logic [PHASE_W-1:0] lookup_sum;
  logic [ADDR_W-1:0]  sin_addr;

  // Stage 1 registers
  logic               s1_valid;
  wave_mode_e         s1_mode;
  logic [ADDR_W-1:0]  s1_sin_addr;
  logic [PLAY_AW-1:0] s1_play_addr;

  logic signed [SAMPLE_W-1:0] rom_value;

  assign mode_chg  = (wave_mode_e'(mode) != mode_q);
  assign acc_step  = en && !mode_chg && (mode_q == MODE_TONE);
  assign play_step = en && !mode_chg && (mode_q == MODE_REPLAY);

  always_ff @(posedge clk) begin
    if (rst) begin
      fcw_q   <= '0;
      shift_q <= '0;
      len_q   <= '0;
      mode_q  <= MODE_TONE;
    end else begin
      fcw_q   <= step;
      shift_q <= phase_shift;
      len_q   <= replay_len;
      mode_q  <= wave_mode_e'(mode);
    end
  end

  dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .clear (mode_chg),
    .adv   (acc_step),
    .inc   (fcw_q),
    .phase (phase)
  );

  dds_play_ctr #(.PLAY_AW(PLAY_AW)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .clear (mode_chg),
    .adv   (play_step),
    .len   (len_q),
    .idx   (play_idx)
  );

  // Phase truncation: keep the top ADDR_W bits of the shifted phase
  assign lookup_sum = phase + shift_q;
  assign sin_addr   = ADDR_W'(lookup_sum >> DROP_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid     <= 1'b0;
      s1_mode      <= MODE_TONE;
      s1_sin_addr  <= '0;
      s1_play_addr <= '0;
    end else begin
      s1_valid     <= en;
      s1_mode      <= mode_q;
      s1_sin_addr  <= sin_addr;
      s1_play_addr <= play_idx;
    end
  end

  dds_wave_rom #(
    .ADDR_W   (ADDR_W),
    .PLAY_AW  (PLAY_AW),
    .SAMPLE_W (SAMPLE_W)
  ) u_rom (
    .sel_replay (s1_mode == MODE_REPLAY),
    .sin_addr   (s1_sin_addr),
    .play_addr  (s1_play_addr),
    .value      (rom_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample       <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample       <= rom_value;
      sample_valid <= s1_valid;
    end
  end

endmodule

// File: rtl/dds_dual_synth_chk.sv
module dds_dual_synth_chk #(
  parameter int PHASE_W  = 24,
  parameter int SAMPLE_W = 12,
  parameter int PLAY_AW  = 6
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       en,
  input logic signed [SAMPLE_W-1:0] sample,
  input logic                       sample_valid,
  input logic [PHASE_W-1:0]         phase,
  input logic [PHASE_W-1:0]         fcw_q,
  input logic [PLAY_AW-1:0]         play_idx,
  input logic [PLAY_AW:0]           len_q,
  input logic                       mode_chg,
  input logic                       acc_step,
  input logic                       play_step
);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)             age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!sample_valid && sample == '0));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    acc_step |=> phase == $past(phase + fcw_q));

  // R6
  replay_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (play_step && ({1'b0, play_idx} + 1'b1 < len_q)) |=> play_idx == $past(play_idx) + 1'b1);

  // R7
  replay_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (play_step && ({1'b0, play_idx} + 1'b1 >= len_q)) |=> play_idx == '0);

  // R8
  mode_restart_chk: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (phase == '0 && play_idx == '0));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !mode_chg) |=> ($stable(phase) && $stable(play_idx)));

  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> sample_valid == $past(en, 2));

endmodule

bind dds_dual_synth dds_dual_synth_chk #(
  .PHASE_W  (PHASE_W),
  .SAMPLE_W (SAMPLE_W),
  .PLAY_AW  (PLAY_AW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .en           (en),
  .sample       (sample),
  .sample_valid (sample_valid),
  .phase        (phase),
  .fcw_q        (fcw_q),
  .play_idx     (play_idx),
  .len_q        (len_q),
  .mode_chg     (mode_chg),
  .acc_step     (acc_step),
  .play_step    (play_step)
);

// File: tb/sim_dds_dual_synth.sv
module sim_dds_dual_synth;

  localparam int  CLK_PERIOD = 10;
  localparam int  PW = 24;
  localparam int  AW = 8;
  localparam int  SW = 12;
  localparam int  QW = 6;
  localparam longint PH_MOD = longint'(1) << PW;
  localparam real AMP = real'((1 << (SW - 1)) - 1);
  localparam real TWO_PI = 6.28318530717958;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic mode = 1'b0;
  logic [PW-1:0] step = '0;
  logic [PW-1:0] phase_shift = '0;
  logic [QW:0]   replay_len = '0;
  logic signed [SW-1:0] sample;
  logic sample_valid;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_dual_synth #(.PHASE_W(PW), .ADDR_W(AW), .SAMPLE_W(SW), .PLAY_AW(QW)) u0 (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .step(step),
    .phase_shift(phase_shift), .replay_len(replay_len),
    .sample(sample), .sample_valid(sample_valid)
  );

  // Behavioural reference: state and a two-entry output queue
  longint m_phase, m_fcw, m_off;
  int m_cnt, m_len, m_mode;
  int q_v[2], q_m[2], q_a[2];

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_fcw = 0; m_off = 0; m_cnt = 0; m_len = 0; m_mode = 0;
      for (int k = 0; k < 2; k++) begin q_v[k] = 0; q_m[k] = 0; q_a[k] = 0; end
    end else begin
      q_v[1] = q_v[0]; q_m[1] = q_m[0]; q_a[1] = q_a[0];
      q_v[0] = int'(en);
      q_m[0] = m_mode;
      if (m_mode == 1) q_a[0] = m_cnt;
      else             q_a[0] = int'(((m_phase + m_off) % PH_MOD) / (longint'(1) << (PW - AW)));
      if (int'(mode) != m_mode) begin
        m_phase = 0; m_cnt = 0; m_mode = int'(mode);
      end else if (en) begin
        if (m_mode == 0) m_phase = (m_phase + m_fcw) % PH_MOD;
        else if (m_cnt + 1 >= m_len) m_cnt = 0;
        else m_cnt = m_cnt + 1;
      end
      m_fcw = longint'(step); m_off = longint'(phase_shift); m_len = int'(replay_len);
    end
  end

  task automatic compare();
    real want;
    int  want_i;
    checks++;
    if (int'(sample_valid) != q_v[1]) begin
      failures++;
      $display("FAIL %s valid: got %0d expected %0d", cur_req, sample_valid, q_v[1]);
    end
    if (q_v[1] != 0) begin
      checks++;
      if (q_m[1] == 1) begin
        want_i = (q_a[1] - (1 << (QW - 1))) * (1 << (SW - QW));
        if (int'(sample) != want_i) begin
          failures++;
          $display("FAIL %s replay sample: got %0d expected %0d (index %0d)",
                   cur_req, sample, want_i, q_a[1]);
        end
      end else begin
        want = AMP * $sin(TWO_PI * real'(q_a[1]) / real'(1 << AW));
        if (real'(sample) - want > 1.0 || want - real'(sample) > 1.0) begin
          failures++;
          $display("FAIL %s tone sample: got %0d expected %f (index %0d)",
                   cur_req, sample, want, q_a[1]);
        end
      end
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!rst) compare();
    end
  endtask

  task automatic reset_check();
    checks++;
    if (sample != '0 || sample_valid != 1'b0) begin
      failures++;
      $display("FAIL R1 reset: got sample=%0d valid=%0d expected 0 0", sample, sample_valid);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset_check();                               // R1 initial reset
    rst = 1'b0; en = 1'b1;

    cur_req = "R3"; step = 24'h010000;           // one table entry per clock
    tick(270);
    cur_req = "R2"; step = 24'h012345;
    tick(150);
    step = 24'hF00001;                           // overflow nearly every clock
    tick(100);
    cur_req = "R4"; phase_shift = 24'h400000;
    tick(60);
    phase_shift = 24'h000000;
    tick(20);
    cur_req = "R5";
    for (int i = 0; i < 200; i++) begin
      step = PW'($urandom); phase_shift = PW'($urandom);
      tick(1);
    end
    cur_req = "R9";
    for (int i = 0; i < 120; i++) begin
      en = (i % 3) != 1;
      tick(1);
    end
    en = 1'b1;

    cur_req = "R8"; mode = 1'b1; replay_len = 7'd64;
    tick(5);
    cur_req = "R6";
    for (int i = 0; i < 150; i++) begin
      step = PW'($urandom);
      tick(1);
    end
    cur_req = "R7"; replay_len = 7'd10;
    tick(40);
    replay_len = 7'd1;
    tick(8);
    replay_len = 7'd0;
    tick(8);
    replay_len = 7'd45;
    tick(30);
    replay_len = 7'd5;                           // lowered below current index
    tick(20);
    cur_req = "R9";
    for (int i = 0; i < 60; i++) begin
      en = (i % 4) == 0;
      tick(1);
    end
    en = 1'b1;

    cur_req = "R8";
    mode = 1'b0; step = 24'h0A0001;
    tick(25);
    mode = 1'b1; replay_len = 7'd33;
    tick(25);
    mode = 1'b0;
    tick(3);
    mode = 1'b1;
    tick(30);

    cur_req = "R1"; rst = 1'b1;
    @(negedge clk);
    reset_check();
    @(negedge clk);
    reset_check();
    rst = 1'b0; mode = 1'b0; step = 24'h003210;
    tick(40);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL %s watchdog: run did not end, got timeout expected completion", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule